// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block is the target side of a 256-location, 8-bit serial EEPROM reached over a two-wire bus (serial clock plus open-drain data). The bus lines are brought in as plain inputs and resampled on a fast system clock. The block finds bus START and STOP events and shifts in the device byte. It answers only when the upper seven bits of that byte carry the fixed device-type code and the three board strap levels. After that it follows a write frame or a read frame. SDA is driven through a single pull-low enable, so the chip pad or the bench forms the wired-AND.

A write frame sets the word address and may carry data bytes, which land in consecutive locations of one 8-byte page. When a frame that stored data is closed, a self-timed programming interval starts. During that interval the device stays silent on its own address, so a master can poll for completion. Reads return the byte at the internal address counter and then advance it. This covers current-address reads, random reads (an address-only write frame followed by a repeated START) and sequential reads that continue while the master acknowledges. A write-protect input blocks every store to the array.

Top module: `ee2w_slave`

## Requirements
- R1: The first byte after a START is taken MSB first. The device acknowledges it only if bits 7..4 equal 1010 and bits 3..1 equal strap[2:0]. Otherwise it does not pull SDA low for the rest of that frame, up to the next START or STOP.
- R2: For every byte the device accepts, it holds SDA low for the whole ninth SCL clock. It changes its SDA drive only while SCL is low.
- R3: A write frame consists of the device byte with bit 0 = 0, then a word address byte, then a data byte. The data byte is stored at that word address.
- R4: Further data bytes in the same write frame go to successive addresses. Only address bits 2..0 advance, so after offset 7 the next byte goes to offset 0 of the same 8-byte page.
- R5: A device byte with bit 0 = 1 starts a read. The read returns the byte at the internal address counter and then increments the counter. The counter wraps from 255 to 0.
- R6: A random read is a write frame carrying only the word address, then a repeated START and a read device byte. The first byte returned is the one at that word address.
- R7: In a read, the device sends another byte each time the master acknowledges with SDA low. When the master leaves SDA high in the acknowledge slot, the device releases SDA and waits for STOP.
- R8: A STOP or repeated START that closes a frame in which at least one byte was stored starts a programming interval of PROG_CYCLES system clocks. During that interval the device byte is not acknowledged. After it ends, the device byte is acknowledged again.
- R9: While wp_in is high, data bytes are acknowledged but the array keeps its old contents, and no programming interval is started.
- R10: During and after reset, SDA is released, the address counter is 0 and the block waits for a START. The array contents are not cleared by reset.
- R11: A STOP at any point returns the block to idle. A write frame that STOPs after the word address stores nothing and starts no interval, but it still sets the address counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_in | input | 1 | Serial clock line level |
| sda_in | input | 1 | Serial data line level (wired-AND bus value) |
| strap | input | 3 | Board-strapped low bits of the device address |
| wp_in | input | 1 | High blocks all stores to the array |
| sda_pull_low | output | 1 | High pulls the data line low, low releases it |

## Verification
The device reacts to an SCL edge three system clocks after the edge reaches its pins: two clocks in the synchroniser and one to register the new SDA drive. Every SCL phase in the bench master therefore lasts six clocks. The bench samples acknowledge bits and read data in the middle of the SCL-high phase, well after the drive has settled. The programming interval counts from the STOP event that the synchroniser sees, so busy polls are issued within a few hundred clocks of the STOP. Completion polls are issued only after PROG_CYCLES plus a margin has passed.

// File: rtl/ee2w_pkg.sv
package ee2w_pkg;

   typedef enum logic [3:0] {
      S_IDLE,
      S_DEV,
      S_DEV_ACK,
      S_ADDR,
      S_ADDR_ACK,
      S_WDATA,
      S_WDATA_ACK,
      S_RDATA,
      S_RACK
   } ee2w_state_e;

endpackage

// File: rtl/ee2w_linesync.sv
module ee2w_linesync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_in,
   input  logic sda_in,
   output logic scl_q,
   output logic sda_q,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_seen,
   output logic stop_seen
);

   if (STAGES < 2) begin : g_bad_stages
      $error("ee2w_linesync: STAGES must be at least 2");
   end

   logic [1:0] raw;
   logic [1:0] synced;
   logic       scl_p, sda_p;

   assign raw = {scl_in, sda_in};

   for (genvar g = 0; g < 2; g++) begin : g_line
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk) begin
         if (!rst_n) chain <= '1;
         else        chain <= {chain[STAGES-2:0], raw[g]};
      end
      assign synced[g] = chain[STAGES-1];
   end

   assign scl_q = synced[1];
   assign sda_q = synced[0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         scl_p <= 1'b1;
         sda_p <= 1'b1;
      end else begin
         scl_p <= scl_q;
         sda_p <= sda_q;
      end
   end

   assign scl_rise   = scl_q & ~scl_p;
   assign scl_fall   = ~scl_q & scl_p;
   assign start_seen = scl_q & scl_p & sda_p & ~sda_q;
   assign stop_seen  = scl_q & scl_p & ~sda_p & sda_q;

endmodule

// File: rtl/ee2w_mem.sv
module ee2w_mem #(
   parameter int AW = 8,
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);

   localparam int DEPTH = 1 << AW;

   logic [DW-1:0] cells [DEPTH];

   always_ff @(posedge clk) begin
      if (we) cells[waddr] <= wdata;
   end

   assign rdata = cells[raddr];

endmodule

// File: rtl/ee2w_progtimer.sv
module ee2w_progtimer #(
   parameter int CYCLES = 20000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic kick,
   output logic busy
);

   if (CYCLES < 1) begin : g_bad_cycles
      $error("ee2w_progtimer: CYCLES must be at least 1");
   end

   localparam int CW = $clog2(CYCLES + 1);

   logic [CW-1:0] remain;

   always_ff @(posedge clk) begin
      if (!rst_n)            remain <= '0;
      else if (kick)         remain <= CW'(CYCLES);
      else if (remain != '0) remain <= remain - CW'(1);
   end

   assign busy = (remain != '0);

endmodule

// File: rtl/ee2w_slave.sv
module ee2w_slave #(
   parameter int         AW          = 8,
   parameter int         DW          = 8,
   parameter int         PAGE_BYTES  = 8,
   parameter int         PROG_CYCLES = 20000,
   parameter int         SYNC_STAGES = 2,
   parameter logic [3:0] DEV_TYPE    = 4'b1010
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       scl_in,
   input  logic       sda_in,
   input  logic [2:0] strap,
   input  logic       wp_in,
   output logic       sda_pull_low
);

   import ee2w_pkg::*;

   localparam int          DEPTH        = 1 << AW;
   localparam int          PW           = $clog2(PAGE_BYTES);
   localparam logic [AW-1:0] PAGE_HI_MASK = (PAGE_BYTES == DEPTH) ? '0 : ~AW'(PAGE_BYTES - 1);

   if (DW != 8) begin : g_bad_dw
      $error("ee2w_slave: the bus moves 8-bit words, DW must be 8");
   end
   if (AW > DW || AW < 1) begin : g_bad_aw
      $error("ee2w_slave: word address must fit one bus byte");
   end
   if (PAGE_BYTES < 2 || PAGE_BYTES > DEPTH || (PAGE_BYTES & (PAGE_BYTES - 1)) != 0) begin : g_bad_page
      $error("ee2w_slave: PAGE_BYTES must be a power of two within the array");
   end

   logic scl_q, sda_q, scl_rise, scl_fall, start_seen, stop_seen;

   ee2w_linesync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
      .scl_q(scl_q), .sda_q(sda_q), .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_seen(start_seen), .stop_seen(stop_seen)
   );

   ee2w_state_e   state;
   logic [3:0]    bitcnt;
   logic [7:0]    shreg;
   logic [7:0]    txreg;
   logic          rw_q, pull_q, wrote_q, mack_q;
   logic [AW-1:0] addr_q, page_next;
   logic [DW-1:0] rdata;
   logic          mem_we, busy, kick, byte_done, dev_hit;

   if (PAGE_BYTES == DEPTH) begin : g_flat
      assign page_next = addr_q + AW'(1);
   end else begin : g_paged
      assign page_next = {addr_q[AW-1:PW], addr_q[PW-1:0] + PW'(1)};
   end

   assign byte_done = scl_fall && (bitcnt == 4'd8);
   assign dev_hit   = (shreg[7:1] == {DEV_TYPE, strap}) && !busy;
   assign mem_we    = (state == S_WDATA) && byte_done && !wp_in;
   assign kick      = (stop_seen || start_seen) && wrote_q;

   ee2w_mem #(.AW(AW), .DW(DW)) u_mem (
      .clk(clk), .we(mem_we), .waddr(addr_q), .wdata(shreg),
      .raddr(addr_q), .rdata(rdata)
   );

   ee2w_progtimer #(.CYCLES(PROG_CYCLES)) u_timer (
      .clk(clk), .rst_n(rst_n), .kick(kick), .busy(busy)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state   <= S_IDLE;
         bitcnt  <= '0;
         shreg   <= '0;
         txreg   <= '0;
         rw_q    <= 1'b0;
         pull_q  <= 1'b0;
         wrote_q <= 1'b0;
         mack_q  <= 1'b0;
         addr_q  <= '0;
      end else if (stop_seen) begin
         state   <= S_IDLE;
         pull_q  <= 1'b0;
         wrote_q <= 1'b0;
      end else if (start_seen) begin
         state   <= S_DEV;
         bitcnt  <= '0;
         pull_q  <= 1'b0;
         wrote_q <= 1'b0;
      end else begin
         case (state)
            S_DEV, S_ADDR, S_WDATA: begin
               if (scl_rise) begin
                  shreg  <= {shreg[6:0], sda_q};
                  bitcnt <= bitcnt + 4'd1;
               end
               if (byte_done) begin
                  bitcnt <= '0;
                  if (state == S_DEV) begin
                     if (dev_hit) begin
                        pull_q <= 1'b1;
                        rw_q   <= shreg[0];
                        state  <= S_DEV_ACK;
                     end else begin
                        state  <= S_IDLE;
                     end
                  end else if (state == S_ADDR) begin
                     addr_q <= shreg[AW-1:0];
                     pull_q <= 1'b1;
                     state  <= S_ADDR_ACK;
                  end else begin
                     addr_q <= page_next;
                     if (!wp_in) wrote_q <= 1'b1;
                     pull_q <= 1'b1;
                     state  <= S_WDATA_ACK;
                  end
               end
            end
            S_DEV_ACK: begin
               if (scl_fall) begin
                  bitcnt <= '0;
                  if (rw_q) begin
                     txreg  <= rdata;
                     pull_q <= ~rdata[7];
                     addr_q <= addr_q + AW'(1);
                     state  <= S_RDATA;
                  end else begin
                     pull_q <= 1'b0;
                     state  <= S_ADDR;
                  end
               end
            end
            S_ADDR_ACK, S_WDATA_ACK: begin
               if (scl_fall) begin
                  pull_q <= 1'b0;
                  state  <= S_WDATA;
               end
            end
            S_RDATA: begin
               if (scl_rise) bitcnt <= bitcnt + 4'd1;
               if (scl_fall) begin
                  if (bitcnt == 4'd8) begin
                     pull_q <= 1'b0;
                     state  <= S_RACK;
                  end else begin
                     txreg  <= {txreg[6:0], 1'b0};
                     pull_q <= ~txreg[6];
                  end
               end
            end
            S_RACK: begin
               if (scl_rise) mack_q <= ~sda_q;
               if (scl_fall) begin
                  if (mack_q) begin
                     txreg  <= rdata;
                     pull_q <= ~rdata[7];
                     addr_q <= addr_q + AW'(1);
                     bitcnt <= '0;
                     state  <= S_RDATA;
                  end else begin
                     state  <= S_IDLE;
                  end
               end
            end
            default: state <= S_IDLE;
         endcase
      end
   end

   assign sda_pull_low = pull_q;

endmodule

// File: rtl/ee2w_chk.sv
module ee2w_chk
   import ee2w_pkg::*;
#(
   parameter int            AW      = 8,
   parameter logic [AW-1:0] HI_MASK = '0
) (
   input logic          clk,
   input logic          rst_n,
   input ee2w_state_e   state,
   input logic          scl_q,
   input logic          stop_seen,
   input logic          busy,
   input logic          wp_in,
   input logic          mem_we,
   input logic          pull,
   input logic [AW-1:0] addr_q
);

   // R2: the drive only moves while the synchronised clock is low
   p_drive_scl_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(pull) |-> !scl_q);

   // R11: a STOP always lands in idle
   p_stop_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
      stop_seen |=> (state == S_IDLE));

   // R8: no address acknowledge while programming
   p_busy_silent_r8: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (state != S_DEV_ACK));

   // R9: protection blocks every array store
   p_wp_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
      wp_in |-> !mem_we);

   // R4: a stored byte never moves the counter out of its page
   p_page_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |=> (((addr_q ^ $past(addr_q)) & HI_MASK) == '0));

   // R10: idle never holds the line low
   p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_IDLE) |-> !pull);

endmodule

bind ee2w_slave ee2w_chk #(.AW(AW), .HI_MASK(PAGE_HI_MASK)) u_chk (
   .clk(clk), .rst_n(rst_n), .state(state), .scl_q(scl_q),
   .stop_seen(stop_seen), .busy(busy), .wp_in(wp_in), .mem_we(mem_we),
   .pull(pull_q), .addr_q(addr_q)
);

// File: tb/ee2w_slave_test.sv
`timescale 1ns/1ps
module ee2w_slave_test;

   localparam int         Q     = 6;
   localparam int         PROG  = 300;
   localparam logic [2:0] STRAP = 3'b101;
   localparam logic [7:0] DEVW  = {4'b1010, STRAP, 1'b0};
   localparam logic [7:0] DEVR  = {4'b1010, STRAP, 1'b1};

   // {word address, data, wp, expected readback}
   localparam logic [24:0] VEC [0:5] = '{
      {8'h10, 8'hA5, 1'b0, 8'hA5},
      {8'h10, 8'h3C, 1'b1, 8'hA5},
      {8'hFF, 8'h81, 1'b0, 8'h81},
      {8'h00, 8'h7E, 1'b0, 8'h7E},
      {8'h55, 8'hC3, 1'b0, 8'hC3},
      {8'h55, 8'h00, 1'b1, 8'hC3}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl = 1'b1;
   logic m_low = 1'b0;
   logic wp = 1'b0;
   logic s_low;
   logic sda_bus;
   int   n_chk = 0;
   int   n_fail = 0;
   bit   done = 0;

   always #4 clk = ~clk;

   assign sda_bus = !(m_low || s_low);

   ee2w_slave #(.PROG_CYCLES(PROG)) uut (
      .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda_bus),
      .strap(STRAP), .wp_in(wp), .sda_pull_low(s_low)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wq();
      repeat (Q) @(negedge clk);
   endtask

   task automatic bit_xfer(input logic b, output logic s);
      m_low = !b; wq();
      scl = 1'b1; wq();
      s = sda_bus; wq();
      scl = 1'b0; wq();
   endtask

   task automatic start_c();
      m_low = 1'b0; wq();
      scl = 1'b1; wq();
      m_low = 1'b1; wq();
      scl = 1'b0; wq();
   endtask

   task automatic stop_c();
      m_low = 1'b1; wq();
      scl = 1'b1; wq();
      m_low = 1'b0; wq(); wq();
   endtask

   task automatic send_byte(input logic [7:0] b, output logic ack);
      logic s;
      for (int i = 7; i >= 0; i--) bit_xfer(b[i], s);
      bit_xfer(1'b1, s);
      ack = !s;
   endtask

   task automatic recv_byte(input logic give_ack, output logic [7:0] d);
      logic s;
      for (int i = 7; i >= 0; i--) begin
         bit_xfer(1'b1, s);
         d[i] = s;
      end
      bit_xfer(!give_ack, s);
   endtask

   task automatic rand_read(input logic [7:0] a, output logic [7:0] d);
      logic k;
      start_c();
      send_byte(DEVW, k); chk(k, "R6 dev ack", k, 1);
      send_byte(a, k);    chk(k, "R6 addr ack", k, 1);
      start_c();
      send_byte(DEVR, k); chk(k, "R6 read dev ack", k, 1);
      recv_byte(1'b0, d);
      stop_c();
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog expired actual=%0h expected=%0h", 0, 1);
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic k;
      logic [7:0] d;
      repeat (5) @(negedge clk);
      chk(s_low == 1'b0, "R10 released in reset", s_low, 0);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      chk(s_low == 1'b0, "R10 released after reset", s_low, 0);

      // R1: wrong strap bits, then stays silent
      start_c();
      send_byte({4'b1010, 3'b011, 1'b0}, k); chk(!k, "R1 strap mismatch nack", k, 0);
      send_byte(8'h00, k);                   chk(!k, "R1 silent after miss", k, 0);
      stop_c();
      start_c();
      send_byte({4'b1011, STRAP, 1'b0}, k);  chk(!k, "R1 type mismatch nack", k, 0);
      stop_c();

      for (int i = 0; i < 6; i++) begin
         logic [7:0] va, vd, ve;
         logic       vw;
         {va, vd, vw, ve} = VEC[i];
         wp = vw;
         start_c();
         send_byte(DEVW, k); chk(k, "R1 dev ack", k, 1);
         send_byte(va, k);   chk(k, "R2 addr ack", k, 1);
         send_byte(vd, k);   chk(k, "R3 data ack", k, 1);
         stop_c();
         wp = 1'b0;
         start_c();
         send_byte(DEVW, k);
         if (vw) chk(k, "R9 no interval after protected write", k, 1);
         else    chk(!k, "R8 busy poll nack", k, 0);
         stop_c();
         repeat (PROG + 40) @(negedge clk);
         start_c();
         send_byte(DEVW, k); chk(k, "R8 poll ack after interval", k, 1);
         stop_c();
         rand_read(va, d);
         if (vw) chk(d == ve, "R9 protected data kept", d, ve);
         else    chk(d == ve, "R3 byte readback", d, ve);
      end

      // R4: page write crossing the page end
      start_c();
      send_byte(DEVW, k); send_byte(8'h2E, k);
      send_byte(8'h11, k); send_byte(8'h22, k);
      send_byte(8'h33, k); send_byte(8'h44, k);
      chk(k, "R4 fourth data ack", k, 1);
      stop_c();
      repeat (PROG + 40) @(negedge clk);

      // R7: sequential read 2E, 2F
      start_c();
      send_byte(DEVW, k); send_byte(8'h2E, k);
      start_c();
      send_byte(DEVR, k);
      recv_byte(1'b1, d); chk(d == 8'h11, "R4 page byte 2E", d, 8'h11);
      recv_byte(1'b0, d); chk(d == 8'h22, "R7 sequential byte 2F", d, 8'h22);
      chk(s_low == 1'b0, "R7 released after master nack", s_low, 0);
      stop_c();
      rand_read(8'h28, d); chk(d == 8'h33, "R4 wrap to page start", d, 8'h33);
      rand_read(8'h29, d); chk(d == 8'h44, "R4 wrap second byte", d, 8'h44);

      // R5: counter wraps 255 -> 0
      rand_read(8'hFF, d); chk(d == 8'h81, "R6 read at FF", d, 8'h81);
      start_c();
      send_byte(DEVR, k); chk(k, "R5 current read ack", k, 1);
      recv_byte(1'b0, d); chk(d == 8'h7E, "R5 counter wrapped", d, 8'h7E);
      stop_c();

      // R10: reset clears the counter, not the array
      rst_n = 1'b0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      start_c();
      send_byte(DEVR, k);
      recv_byte(1'b0, d); chk(d == 8'h7E, "R10 counter zero after reset", d, 8'h7E);
      stop_c();

      // R11: STOP after word address
      start_c();
      send_byte(DEVW, k); send_byte(8'h55, k);
      stop_c();
      start_c();
      send_byte(DEVR, k); chk(k, "R11 no interval after address-only frame", k, 1);
      recv_byte(1'b0, d); chk(d == 8'hC3, "R11 address kept", d, 8'hC3);
      stop_c();

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

endmodule